// File: doc/BRIEF.md
# Programmable bus timeout counter

This block guards an on-chip system bus against lockups. It has two independent watch channels. One counts consecutive bus clock cycles spent in wait states. The other counts consecutive cycles during which a grant request stays pending. Each channel has a 4-bit setting that selects its expiry limit. When the count reaches that limit, the channel emits a one-cycle timeout pulse and sets a sticky status bit. The status bit stays set until a clear input is applied.

A setting of zero disables expiry. Settings 1 to 14 select a limit of 4^s cycles. The top setting, 15, selects 2^31 cycles. The count restarts whenever the watched condition drops. A new setting is taken only while the channel is idle, so a limit cannot change partway through an episode. Arbitration and recovery are left to the logic that consumes the flags.

Top module: `bus_timeout_watch`

## Requirements
- R1: With setting 0 latched, the channel never pulses and never sets its sticky bit, however long its condition holds.
- R2: With setting s in 1..14 latched, the limit is L = 2^(2*s) consecutive cycles. If the condition is sampled high at L consecutive rising edges, the pulse is high for exactly the cycle that follows the L-th edge. Examples: s=1 gives 4, s=2 gives 16, s=5 gives 1024.
- R3: Setting 15 selects a limit of 2^31 cycles, not 2^30.
- R4: The count returns to zero on any edge where the condition is sampled low. Only unbroken runs reach the limit.
- R5: The pulse fires at most once per episode. After expiry the count holds at the limit and does not wrap while the condition stays high.
- R6: The sticky bit is set on the same edge that raises the pulse. It then stays set until an edge where clear is sampled high and no new pulse is being raised. When set and clear coincide, set wins.
- R7: The setting input is captured only on edges where the condition is sampled low. A change made while the condition is high has no effect on the running episode.
- R8: The wait-state channel and the grant channel have separate inputs and outputs. Activity on one never changes the pulse or sticky bit of the other.
- R9: During and right after reset, both pulses and both sticky bits are 0, and the latched setting of each channel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| waitActive | input | 1 | Bus is in a wait state this cycle |
| waitSel | input | 4 | Limit setting for the wait-state channel |
| waitClr | input | 1 | Clears the wait-state sticky bit |
| waitPulse | output | 1 | One-cycle wait-state timeout |
| waitSticky | output | 1 | Sticky wait-state timeout status |
| grantActive | input | 1 | A grant request is pending this cycle |
| grantSel | input | 4 | Limit setting for the grant channel |
| grantClr | input | 1 | Clears the grant sticky bit |
| grantPulse | output | 1 | One-cycle grant timeout |
| grantSticky | output | 1 | Sticky grant timeout status |

## Verification
Most internal faults surface at the ports through the timing of the pulse. A count that is off by one, or a wrong exponent in the limit mapping, moves the pulse by at least one cycle away from edge 4^s. The bench catches this on the first episode of a small setting. A count that fails to restart, or a latch that takes the setting mid-episode, produces a pulse where none is due, or at the wrong edge, within a few dozen cycles. A missing saturation produces a second pulse inside the same long episode. A fault in the sticky path shows on the very next sample after a pulse or a clear.

// File: rtl/bto_pkg.sv
package bto_pkg;
  localparam int CNT_W   = 32;
  localparam int SEL_W   = 4;
  localparam int TOP_SEL = (1 << SEL_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    sel_t selLatched;
  } ctl_strobe_t;

  // setting -> expiry limit; 0 means no limit
  function automatic cnt_t limit_of(sel_t s);
    cnt_t r;
    if (s == '0)
      r = '0;
    else if (int'(s) == TOP_SEL)
      r = cnt_t'(1) << (CNT_W - 1);
    else
      r = cnt_t'(1) << (2 * int'(s));
    return r;
  endfunction
endpackage

// File: rtl/bto_datapath.sv
module bto_datapath
  import bto_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t ctl,
  output logic        hitNext,
  output logic        atLimit
);
  cnt_t cnt;
  cnt_t lim;
  logic armed;

  assign lim   = limit_of(ctl.selLatched);
  assign armed = (ctl.selLatched != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (ctl.cntClr)
      cnt <= '0;
    else if (ctl.cntInc && (cnt != '1))
      cnt <= cnt + 1'b1;
  end

  assign hitNext = armed && (cnt == lim - 1'b1);
  assign atLimit = armed && (cnt == lim);
endmodule

// File: rtl/bto_ctrl.sv
module bto_ctrl
  import bto_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        active,
  input  sel_t        selIn,
  input  logic        clr,
  input  logic        hitNext,
  input  logic        atLimit,
  output ctl_strobe_t ctl,
  output logic        pulse,
  output logic        sticky
);
  sel_t selQ;
  logic fire;

  assign fire = active && hitNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      selQ <= '0;
    else if (!active)
      selQ <= selIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulse  <= 1'b0;
      sticky <= 1'b0;
    end else begin
      pulse  <= fire;
      sticky <= fire | (sticky & ~clr);
    end
  end

  always_comb begin
    ctl.cntInc     = active && !atLimit;
    ctl.cntClr     = !active;
    ctl.selLatched = selQ;
  end
endmodule

// File: rtl/bus_timeout_watch.sv
module bus_timeout_watch
  import bto_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             waitActive,
  input  logic [SEL_W-1:0] waitSel,
  input  logic             waitClr,
  output logic             waitPulse,
  output logic             waitSticky,
  input  logic             grantActive,
  input  logic [SEL_W-1:0] grantSel,
  input  logic             grantClr,
  output logic             grantPulse,
  output logic             grantSticky
);
  ctl_strobe_t waitCtl, grantCtl;
  logic waitHit, waitAt, grantHit, grantAt;

  bto_ctrl u_waitCtrl (
    .clk(clk), .rstN(rstN), .active(waitActive), .selIn(waitSel), .clr(waitClr),
    .hitNext(waitHit), .atLimit(waitAt), .ctl(waitCtl),
    .pulse(waitPulse), .sticky(waitSticky)
  );
  bto_datapath u_waitDp (
    .clk(clk), .rstN(rstN), .ctl(waitCtl), .hitNext(waitHit), .atLimit(waitAt)
  );

  bto_ctrl u_grantCtrl (
    .clk(clk), .rstN(rstN), .active(grantActive), .selIn(grantSel), .clr(grantClr),
    .hitNext(grantHit), .atLimit(grantAt), .ctl(grantCtl),
    .pulse(grantPulse), .sticky(grantSticky)
  );
  bto_datapath u_grantDp (
    .clk(clk), .rstN(rstN), .ctl(grantCtl), .hitNext(grantHit), .atLimit(grantAt)
  );
endmodule

// File: rtl/bto_checker.sv
module bto_checker (
  input logic clk,
  input logic rstN,
  input logic waitActive,
  input logic waitClr,
  input logic waitPulse,
  input logic waitSticky,
  input logic grantActive,
  input logic grantClr,
  input logic grantPulse,
  input logic grantSticky
);
  assert_wait_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    waitPulse |=> !waitPulse);
  assert_grant_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    grantPulse |=> !grantPulse);

  assert_wait_pulse_needs_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    waitPulse |-> $past(waitActive));
  assert_grant_pulse_needs_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    grantPulse |-> $past(grantActive));

  assert_wait_sticky_with_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    waitPulse |-> waitSticky);
  assert_grant_sticky_with_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    grantPulse |-> grantSticky);

  assert_wait_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (waitSticky && !waitClr) |=> waitSticky);
  assert_grant_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (grantSticky && !grantClr) |=> grantSticky);

  assert_wait_sticky_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitSticky) |-> waitPulse);
  assert_grant_sticky_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantSticky) |-> grantPulse);
endmodule

bind bus_timeout_watch bto_checker u_chk (
  .clk(clk), .rstN(rstN),
  .waitActive(waitActive), .waitClr(waitClr), .waitPulse(waitPulse), .waitSticky(waitSticky),
  .grantActive(grantActive), .grantClr(grantClr), .grantPulse(grantPulse), .grantSticky(grantSticky)
);

// File: tb/bus_timeout_watch_tb.sv
module bus_timeout_watch_tb;
  import bto_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] sel;
    int         runLen;
    int         expAt;   // 0 = no pulse expected
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{sel: 4'd1, runLen: 3,    expAt: 0},
    '{sel: 4'd1, runLen: 4,    expAt: 4},
    '{sel: 4'd1, runLen: 12,   expAt: 4},
    '{sel: 4'd2, runLen: 15,   expAt: 0},
    '{sel: 4'd2, runLen: 16,   expAt: 16},
    '{sel: 4'd3, runLen: 64,   expAt: 64},
    '{sel: 4'd3, runLen: 150,  expAt: 64},
    '{sel: 4'd4, runLen: 256,  expAt: 256},
    '{sel: 4'd5, runLen: 1030, expAt: 1024}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic waitActive = 1'b0, waitClr = 1'b0, grantActive = 1'b0, grantClr = 1'b0;
  logic [3:0] waitSel = '0, grantSel = '0;
  logic waitPulse, waitSticky, grantPulse, grantSticky;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_timeout_watch u_dut (
    .clk(clk), .rstN(rstN),
    .waitActive(waitActive), .waitSel(waitSel), .waitClr(waitClr),
    .waitPulse(waitPulse), .waitSticky(waitSticky),
    .grantActive(grantActive), .grantSel(grantSel), .grantClr(grantClr),
    .grantPulse(grantPulse), .grantSticky(grantSticky)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one episode on a channel: latch setting while idle, then hold the condition n cycles
  task automatic episode(input bit grantCh, input logic [3:0] sel, input int n,
                         output int pulses, output int firstAt);
    pulses = 0; firstAt = 0;
    @(negedge clk);
    if (grantCh) begin grantSel = sel; grantActive = 1'b0; end
    else begin waitSel = sel; waitActive = 1'b0; end
    @(negedge clk);
    if (grantCh) grantActive = 1'b1; else waitActive = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (grantCh ? grantPulse : waitPulse) begin
        pulses++;
        if (firstAt == 0) firstAt = i;
      end
    end
    if (grantCh) grantActive = 1'b0; else waitActive = 1'b0;
  endtask

  task automatic clearWait();
    @(negedge clk); waitClr = 1'b1;
    @(negedge clk); waitClr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p, f;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(!waitPulse && !waitSticky && !grantPulse && !grantSticky, "R9 reset outputs",
          {waitPulse, waitSticky, grantPulse, grantSticky}, 0);
    rstN = 1'b1;
    // R9: latched setting is 0 after reset -> holding condition does nothing
    @(negedge clk); waitActive = 1'b1;
    repeat (20) @(negedge clk);
    check(!waitSticky, "R9 latched setting zero after reset", waitSticky, 0);
    waitActive = 1'b0;

    // R2, R5, R6, R8: table walk on the wait channel
    for (int v = 0; v < NV; v++) begin
      episode(1'b0, VEC[v].sel, VEC[v].runLen, p, f);
      check(f == VEC[v].expAt, "R2 pulse edge", f, VEC[v].expAt);
      check(p == (VEC[v].expAt != 0 ? 1 : 0), "R5 pulse count per episode", p,
            (VEC[v].expAt != 0 ? 1 : 0));
      @(negedge clk);
      check(waitSticky == (VEC[v].expAt != 0), "R6 sticky after episode", waitSticky,
            (VEC[v].expAt != 0));
      check(!grantSticky && !grantPulse, "R8 grant untouched", grantSticky, 0);
      clearWait();
      @(negedge clk);
      check(!waitSticky, "R6 sticky cleared", waitSticky, 0);
    end

    // R1: setting 0 never expires
    episode(1'b0, 4'd0, 400, p, f);
    @(negedge clk);
    check(p == 0 && !waitSticky, "R1 never expires", p, 0);

    // R3: top setting limit and long run without expiry
    check(limit_of(4'd15) == 64'h8000_0000, "R3 top setting limit", limit_of(4'd15), 64'h8000_0000);
    episode(1'b0, 4'd15, 1100, p, f);
    check(p == 0, "R3 no early expiry", p, 0);

    // R4: broken runs restart the count (setting 1, limit 4)
    @(negedge clk); waitSel = 4'd1;
    @(negedge clk); waitActive = 1'b1;
    repeat (3) @(negedge clk);
    waitActive = 1'b0;
    @(negedge clk); waitActive = 1'b1;
    p = 0;
    for (int i = 1; i <= 3; i++) begin @(negedge clk); if (waitPulse) p++; end
    check(p == 0 && !waitSticky, "R4 restart after drop", p, 0);
    @(negedge clk);
    check(waitPulse == 1'b1, "R4 full run after restart", waitPulse, 1);
    waitActive = 1'b0;
    clearWait();

    // R7: setting change while active is ignored
    @(negedge clk); waitSel = 4'd1;
    @(negedge clk); waitActive = 1'b1;
    @(negedge clk); waitSel = 4'd3;
    f = 0;
    for (int i = 2; i <= 10; i++) begin
      @(negedge clk);
      if (waitPulse && f == 0) f = i;
    end
    check(f == 4, "R7 setting frozen mid-episode", f, 4);
    waitActive = 1'b0;
    clearWait();
    // R7: new setting (3, limit 64) takes effect once idle
    episode(1'b0, 4'd3, 70, p, f);
    check(f == 64, "R7 setting taken while idle", f, 64);
    clearWait();

    // R6: set wins over clear, then clear applies
    @(negedge clk); waitSel = 4'd1; waitClr = 1'b1;
    @(negedge clk); waitActive = 1'b1;
    repeat (4) @(negedge clk);
    check(waitSticky == 1'b1, "R6 set wins over clear", waitSticky, 1);
    @(negedge clk);
    check(waitSticky == 1'b0, "R6 clear after set", waitSticky, 0);
    waitActive = 1'b0; waitClr = 1'b0;

    // R8: grant channel on its own
    episode(1'b1, 4'd2, 20, p, f);
    @(negedge clk);
    check(f == 16 && p == 1, "R8 grant channel limit", f, 16);
    check(grantSticky && !waitSticky, "R8 channels independent", waitSticky, 0);

    finish_run();
  end
endmodule